// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block evaluates a conditional trap instruction. It takes two register operands, a 5-bit condition mask and a size select. Each bit of the mask enables one comparison between operand A and operand B: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. The unit raises a program-exception trap request when at least one enabled comparison is true.

A word-size request compares only the low 32 bits of each operand. The operands are sign-extended or zero-extended from bit 31, as each comparison needs. A doubleword request compares all 64 bits.

One clock after a valid request, the unit gives a single-cycle trap strobe and an 8-bit reason code. The reason code carries a fixed program-trap class and the set of comparisons that matched. The reason code stays unchanged until the next valid request. Instruction decode and exception dispatch sit outside the block.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when A is less than B, compared as signed numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B, compared as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R4: Mask bit 1 (value 0x02) enables a trap when A is less than B, compared as unsigned numbers.
- R5: Mask bit 0 (value 0x01) enables a trap when A is greater than B, compared as unsigned numbers.
- R6: When `dword_i` is 0 (word size), only bits 31:0 of each operand take part in the comparison. Bit 31 is the sign for the signed tests, and bits 63:32 have no effect on the outputs.
- R7: When `dword_i` is 1 (doubleword size), all 64 bits are compared, and bit 63 is the sign for the signed tests.
- R8: The trap fires on the OR of the enabled comparison results. A mask of 0 never traps, and a mask of 0x1F always traps.
- R9: `trap_o` is a one-cycle pulse that appears on the clock edge after the edge that samples `valid_i`. Without a valid request, `trap_o` is 0.
- R10: `reason_o` is loaded on every valid request, whether or not a trap fires. Bits 7:5 hold the program-trap class 3'b101. Bits 4:0 hold the mask ANDed with the comparison results, in the same bit positions as the mask. `reason_o` holds its value while `valid_i` is low.
- R11: A synchronous active-high `rst` clears `trap_o` and `reason_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe, one cycle per request |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| cond_i | input | 5 | Condition mask selecting the comparisons |
| dword_i | input | 1 | Size select: 0 = word, 1 = doubleword |
| trap_o | output | 1 | Registered trap request pulse |
| reason_o | output | 8 | Class code and matched-comparison bits |

## Verification
A wrong comparison flag or a wrong extension of an operand shows up one clock after the request, in two places. `trap_o` has the wrong value, and the hit bits of `reason_o` differ from the bits the mask selects. Random operands alone rarely produce equal values or values near bit 31 and bit 63, so directed cases drive equal operands, sign-boundary values and differing upper halves in word size. A fault in the output register shows up as a pulse that lasts longer than one cycle, or as a reason code that drifts during idle cycles. Both are visible in the cycles right after a request.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int XLEN   = 64;
    localparam int WORD_W = 32;
    localparam int COND_W = 5;
    localparam int CLS_W  = 3;

    // bit positions of the condition mask (decoded by the instruction field)
    localparam int C_SLT = 4;
    localparam int C_SGT = 3;
    localparam int C_EQ  = 2;
    localparam int C_ULT = 1;
    localparam int C_UGT = 0;

    localparam logic [CLS_W-1:0] PROG_TRAP_CLASS = 3'b101;

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } op_size_e;

    // packed order matches the mask bit positions above
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } cmp_flags_t;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [COND_W-1:0] hits;
    } trap_reason_t;

    function automatic logic [COND_W-1:0] flags_to_vec(cmp_flags_t f);
        return {f.slt, f.sgt, f.eq, f.ult, f.ugt};
    endfunction

endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep
    import trap_cmp_pkg::*;
#(
    parameter int OP_W   = XLEN,
    parameter int NARROW = WORD_W
) (
    input  logic [OP_W-1:0] op_i,
    input  op_size_e        size_i,
    output logic [OP_W:0]   sext_o,
    output logic [OP_W:0]   zext_o
);
    localparam int PAD_W = OP_W + 1 - NARROW;

    always_comb begin
        if (size_i == SZ_DWORD) begin
            sext_o = {op_i[OP_W-1], op_i};
            zext_o = {1'b0, op_i};
        end else begin
            sext_o = {{PAD_W{op_i[NARROW-1]}}, op_i[NARROW-1:0]};
            zext_o = {{PAD_W{1'b0}}, op_i[NARROW-1:0]};
        end
    end

endmodule

// File: rtl/trap_comparator.sv
module trap_comparator
    import trap_cmp_pkg::*;
#(
    parameter int CW = XLEN + 1
) (
    input  logic [CW-1:0] a_s_i,
    input  logic [CW-1:0] b_s_i,
    input  logic [CW-1:0] a_u_i,
    input  logic [CW-1:0] b_u_i,
    output cmp_flags_t    flags_o
);
    always_comb begin
        flags_o.slt = $signed(a_s_i) < $signed(b_s_i);
        flags_o.sgt = $signed(a_s_i) > $signed(b_s_i);
        flags_o.eq  = (a_u_i == b_u_i);
        flags_o.ult = a_u_i < b_u_i;
        flags_o.ugt = a_u_i > b_u_i;
    end

endmodule

// File: rtl/trap_out_reg.sv
module trap_out_reg
    import trap_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [COND_W-1:0] cond_i,
    input  cmp_flags_t        flags_i,
    output logic              trap_q_o,
    output trap_reason_t      reason_q_o
);
    logic [COND_W-1:0] hits;
    logic              fire;

    always_comb begin
        hits = cond_i & flags_to_vec(flags_i);
        fire = |hits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q_o   <= 1'b0;
            reason_q_o <= '0;
        end else begin
            trap_q_o <= valid_i && fire;
            if (valid_i) begin
                reason_q_o.cls  <= PROG_TRAP_CLASS;
                reason_q_o.hits <= hits;
            end
        end
    end

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !trap_q_o); // R9
    AST_REASON_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(reason_q_o)); // R10
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == '0) |=> !trap_q_o); // R8
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == '1) |=> trap_q_o); // R8
    AST_TRAP_MATCH: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (trap_q_o == (reason_q_o.hits != '0))); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!trap_q_o && reason_q_o == '0)); // R11

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
    import trap_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [XLEN-1:0]   op_a_i,
    input  logic [XLEN-1:0]   op_b_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              dword_i,
    output logic              trap_o,
    output logic [7:0]        reason_o
);
    localparam int NUM_OPS = 2;
    localparam int EXT_W   = XLEN + 1;

    op_size_e         size;
    logic [XLEN-1:0]  ops  [NUM_OPS];
    logic [EXT_W-1:0] sext [NUM_OPS];
    logic [EXT_W-1:0] zext [NUM_OPS];
    cmp_flags_t       flags;
    logic             trap_q;
    trap_reason_t     reason_q;

    assign size   = op_size_e'(dword_i);
    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_prep
        trap_operand_prep #(
            .OP_W   (XLEN),
            .NARROW (WORD_W)
        ) u_prep (
            .op_i   (ops[g]),
            .size_i (size),
            .sext_o (sext[g]),
            .zext_o (zext[g])
        );
    end

    trap_comparator #(
        .CW (EXT_W)
    ) u_cmp (
        .a_s_i   (sext[0]),
        .b_s_i   (sext[1]),
        .a_u_i   (zext[0]),
        .b_u_i   (zext[1]),
        .flags_o (flags)
    );

    trap_out_reg u_out (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .cond_i     (cond_i),
        .flags_i    (flags),
        .trap_q_o   (trap_q),
        .reason_q_o (reason_q)
    );

    assign trap_o   = trap_q;
    assign reason_o = reason_q;

    AST_SIGNED_EXCL: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> $onehot({flags.slt, flags.sgt, flags.eq})); // R3
    AST_UNSIGNED_EXCL: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> $onehot({flags.ult, flags.ugt, flags.eq})); // R4
    AST_WORD_EQ_LOW: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !dword_i && op_a_i[WORD_W-1:0] == op_b_i[WORD_W-1:0]) |-> flags.eq); // R6

endmodule

// File: tb/trap_cmp_unit_bench.sv
module trap_cmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [63:0] op_a_i;
    logic [63:0] op_b_i;
    logic [4:0]  cond_i;
    logic        dword_i;
    logic        trap_o;
    logic [7:0]  reason_o;

    int total = 0;
    int bad   = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    trap_cmp_unit u_trap_cmp_unit (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .cond_i   (cond_i),
        .dword_i  (dword_i),
        .trap_o   (trap_o),
        .reason_o (reason_o)
    );

    // expected {trap, reason} computed from the requirements
    function automatic logic [8:0] expect_out(logic [63:0] a, logic [63:0] b,
                                              logic [4:0] c, logic dw);
        longint          sa, sb;
        longint unsigned ua, ub;
        logic [4:0]      res, hit;
        if (dw) begin
            sa = longint'(a); sb = longint'(b);
            ua = a;           ub = b;
        end else begin
            sa = longint'($signed(a[31:0]));
            sb = longint'($signed(b[31:0]));
            ua = {32'd0, a[31:0]};
            ub = {32'd0, b[31:0]};
        end
        res = {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
        hit = res & c;
        return {|hit, 3'b101, hit};
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual trap=%0b reason=%02h expected trap=%0b reason=%02h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // one request, result sampled on the following negedge, then one idle check
    task automatic run(string tag, logic [63:0] a, logic [63:0] b, logic [4:0] c, logic dw);
        logic [8:0] exp;
        exp = expect_out(a, b, c, dw);
        @(negedge clk);
        valid_i = 1'b1; op_a_i = a; op_b_i = b; cond_i = c; dword_i = dw;
        @(negedge clk);
        valid_i = 1'b0;
        op_a_i = ~a; op_b_i = b ^ 64'h5A5A; cond_i = ~c;
        check(tag, {trap_o, reason_o}, exp);
        @(negedge clk);
        check({tag, " R9 pulse ends, R10 hold"}, {trap_o, reason_o}, {1'b0, exp[7:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; valid_i = 1'b0; op_a_i = '0; op_b_i = '0; cond_i = '0; dword_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset state", {trap_o, reason_o}, 9'h000);
        rst = 1'b0;

        run("R1 signed lt",            64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 1'b1);
        run("R4 unsigned lt false",    64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 1'b1);
        run("R5 unsigned gt",          64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1);
        run("R2 signed gt",            64'd5, 64'd3, 5'h08, 1'b1);
        run("R2 signed gt false",      64'd3, 64'd5, 5'h08, 1'b1);
        run("R4 unsigned lt",          64'd3, 64'd5, 5'h02, 1'b1);
        run("R3 equal",                64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b1);
        run("R3 not equal",            64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04, 1'b1);
        run("R6 word ignores upper",   64'hFFFF_FFFF_0000_0007, 64'h0000_0000_0000_0007, 5'h04, 1'b0);
        run("R7 dword sees upper",     64'hFFFF_FFFF_0000_0007, 64'h0000_0000_0000_0007, 5'h04, 1'b1);
        run("R6 word sign bit31",      64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b0);
        run("R7 dword bit31 positive", 64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b1);
        run("R6 word unsigned gt",     64'h0000_0000_8000_0000, 64'd0, 5'h01, 1'b0);
        run("R7 dword sign bit63",     64'h8000_0000_0000_0000, 64'd0, 5'h10, 1'b1);
        run("R8 zero mask",            64'd1, 64'd2, 5'h00, 1'b1);
        run("R8 full mask",            64'd9, 64'd9, 5'h1F, 1'b0);
        run("R8 mixed mask",           64'd1, 64'd2, 5'h0A, 1'b1);

        // back-to-back requests: two pulses, reason follows each
        begin
            logic [8:0] e1, e2;
            e1 = expect_out(64'd1, 64'd2, 5'h10, 1'b1);
            e2 = expect_out(64'd2, 64'd2, 5'h10, 1'b1);
            @(negedge clk);
            valid_i = 1'b1; op_a_i = 64'd1; op_b_i = 64'd2; cond_i = 5'h10; dword_i = 1'b1;
            @(negedge clk);
            check("R9 back-to-back first", {trap_o, reason_o}, e1);
            op_a_i = 64'd2;
            @(negedge clk);
            valid_i = 1'b0;
            check("R10 back-to-back second loads", {trap_o, reason_o}, e2);
        end

        // idle hold over several cycles after a trap
        run("R10 trap before idle", 64'd7, 64'd3, 5'h08, 1'b1);
        repeat (4) @(negedge clk);
        check("R10 hold over idle", {trap_o, reason_o}, {1'b0, expect_out(64'd7, 64'd3, 5'h08, 1'b1) & 9'h0FF});

        // reset right after a trapping request
        @(negedge clk);
        valid_i = 1'b1; op_a_i = 64'd1; op_b_i = 64'd1; cond_i = 5'h04; dword_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R11 reset clears", {trap_o, reason_o}, 9'h000);
        rst = 1'b0;

        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            case ($urandom_range(0, 3))
                0: b = a;
                1: b[31:0] = a[31:0];
                2: b = a ^ 64'h0000_0000_8000_0000;
                default: ;
            endcase
            run("R1 R2 R3 R4 R5 R8 random", a, b, 5'($urandom()), 1'($urandom()));
        end

        report();
        $finish;
    end

endmodule